// File: doc/BRIEF.md
# Serial Polynomial-Division Signature Analyzer

This block compacts one serial response stream from a circuit under test into a short signature and then judges that signature against a known-good value. Each accepted bit is taken as the next coefficient of a polynomial, highest degree first. The register divides that polynomial by a fixed characteristic polynomial and keeps only the running remainder. The division uses the internal-XOR form: the most significant stage feeds back into the XOR gates that sit between the stages.

A test sequence starts with a synchronous clear, which loads the seed (normally zero). The response bits follow, each qualified by a valid strobe. Finally a done strobe asks for a verdict. One cycle after done, a verdict-valid pulse appears, and the go output reports whether the remainder matched the golden signature applied at the golden input. The width, the low coefficients of the characteristic polynomial and the seed are parameters. The default instance is 5 bits wide and divides by 1 + X + X^3 + X^5.

Top module: `sig_analyzer`

## Requirements
- R1: While rst is high at a clock edge, the next state has sig equal to SEED, go = 0 and verdict_vld = 0.
- R2: When clr is high at a clock edge, sig becomes SEED on that edge, even if din_vld is also high.
- R3: When din_vld is low and clr is low, sig keeps its value, whatever din carries.
- R4: Each edge with din_vld high (and clr low) takes din as the next coefficient in decreasing order of degree. After a run of bits from a zero seed, sig[i] equals the coefficient of X^i in the remainder of the input polynomial divided by the characteristic polynomial.
- R5: Parameter POLY gives the coefficients of X^0..X^(WIDTH-1) of the characteristic polynomial, with bit i holding the coefficient of X^i. The X^WIDTH term is implicit. The default WIDTH=5, POLY=5'b01011 divides by 1 + X + X^3 + X^5.
- R6: From a zero seed, the default instance fed the bits 1,0,0,0,1,0,1,0 (coefficient of X^7 first, X^0 last) ends with sig = 5'b01101, that is X0..X4 = 1,0,1,1,0.
- R7: verdict_vld is high exactly in the cycle after done was high. In that cycle, go is 1 when the sig present during the done cycle equalled the golden value present during the done cycle, and 0 otherwise.
- R8: go keeps its value in every cycle that does not follow a done cycle.
- R9: A bit accepted in the same cycle as done still shifts into sig, but it is not part of that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the signature to the seed |
| din | input | 1 | Serial response bit |
| din_vld | input | 1 | Qualifies din for one shift |
| done | input | 1 | Requests a verdict on the current signature |
| golden | input | WIDTH | Fault-free signature to compare against |
| sig | output | WIDTH | Current remainder; bit i is the coefficient of X^i |
| verdict_vld | output | 1 | Pulses one cycle after done |
| go | output | 1 | 1 = signature matched golden at the last verdict |

## Verification
Every 8-bit stream, 256 in all, is shifted in from a zero seed. Each remainder is compared with a long division done in the bench, and a matching golden value and a value one bit off are both offered, so a shift-order or feedback-tap error cannot hide among the streams. The fixed stream of R6 pins the bit order and the implicit top term against a hand-computed remainder. The all-zero and single-one streams are part of the sweep, and they separate a missing seed load from a wrong tap. Separate short sequences interleave idle cycles with toggling din, collide clr with din_vld, and collide done with a shift, which tells hold, clear priority and verdict timing apart.

// File: rtl/sig_pkg.sv
package sig_pkg;

    // What the signature register does on the coming edge.
    typedef enum logic [1:0] {
        SIG_OP_HOLD  = 2'd0,
        SIG_OP_LOAD  = 2'd1,
        SIG_OP_SHIFT = 2'd2
    } sig_op_e;

    // Registered outcome of a compare request.
    typedef struct packed {
        logic vld;
        logic go;
    } verdict_t;

    // Clear wins over a data shift.
    function automatic sig_op_e pick_op(input logic clr, input logic vld);
        if (clr)      return SIG_OP_LOAD;
        else if (vld) return SIG_OP_SHIFT;
        else          return SIG_OP_HOLD;
    endfunction

endpackage

// File: rtl/sig_divider.sv
module sig_divider
    import sig_pkg::*;
#(
    parameter int unsigned       WIDTH = 5,
    parameter logic [WIDTH-1:0]  POLY  = 5'b01011,
    parameter logic [WIDTH-1:0]  SEED  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  sig_op_e          op,
    input  logic             din,
    output logic [WIDTH-1:0] rem
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] rem_shifted;
    logic             carry_out;

    // The coefficient leaving the top stage feeds back into every
    // stage whose polynomial coefficient is set.
    assign carry_out = rem_q[TOP];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                if (POLY[0]) begin : g_tap
                    assign rem_shifted[0] = din ^ carry_out;
                end else begin : g_notap
                    assign rem_shifted[0] = din;
                end
            end else begin : g_body
                if (POLY[i]) begin : g_tap
                    assign rem_shifted[i] = rem_q[i-1] ^ carry_out;
                end else begin : g_notap
                    assign rem_shifted[i] = rem_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= SEED;
        end else begin
            unique case (op)
                SIG_OP_LOAD:  rem_q <= SEED;
                SIG_OP_SHIFT: rem_q <= rem_shifted;
                default:      rem_q <= rem_q;
            endcase
        end
    end

    assign rem = rem_q;

endmodule

// File: rtl/sig_judge.sv
module sig_judge
    import sig_pkg::*;
#(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [WIDTH-1:0] sig,
    input  logic [WIDTH-1:0] golden,
    output verdict_t         verdict
);

    logic [WIDTH-1:0] diff;
    logic             match;
    verdict_t         verdict_q;

    assign diff  = sig ^ golden;
    assign match = (diff == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.vld <= done;
            if (done) begin
                verdict_q.go <= match;
            end
        end
    end

    assign verdict = verdict_q;

endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
    import sig_pkg::*;
#(
    parameter int unsigned       WIDTH = 5,
    parameter logic [WIDTH-1:0]  POLY  = 5'b01011,
    parameter logic [WIDTH-1:0]  SEED  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             din,
    input  logic             din_vld,
    input  logic             done,
    input  logic [WIDTH-1:0] golden,
    output logic [WIDTH-1:0] sig,
    output logic             verdict_vld,
    output logic             go
);

    sig_op_e          op;
    logic [WIDTH-1:0] rem;
    verdict_t         verdict;

    assign op = pick_op(clr, din_vld);

    sig_divider #(
        .WIDTH (WIDTH),
        .POLY  (POLY),
        .SEED  (SEED)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (din),
        .rem (rem)
    );

    // The compare sees the remainder held during the done cycle, so a
    // bit shifting on that same edge lands after the verdict.
    sig_judge #(
        .WIDTH (WIDTH)
    ) u_judge (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .sig     (rem),
        .golden  (golden),
        .verdict (verdict)
    );

    assign sig         = rem;
    assign verdict_vld = verdict.vld;
    assign go          = verdict.go;

endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
    parameter int unsigned       WIDTH = 5,
    parameter logic [WIDTH-1:0]  SEED  = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             din_vld,
    input logic             done,
    input logic [WIDTH-1:0] golden,
    input logic [WIDTH-1:0] sig,
    input logic             verdict_vld,
    input logic             go
);

    p_clear_seed_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sig == SEED));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !din_vld) |=> $stable(sig));

    p_verdict_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> verdict_vld);

    p_no_stray_verdict_r7: assert property (@(posedge clk) disable iff (rst)
        !done |=> !verdict_vld);

    p_go_compare_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (go == ($past(sig) == $past(golden))));

    p_go_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(go));

endmodule

bind sig_analyzer sig_analyzer_chk #(
    .WIDTH (WIDTH),
    .SEED  (SEED)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .din_vld     (din_vld),
    .done        (done),
    .golden      (golden),
    .sig         (sig),
    .verdict_vld (verdict_vld),
    .go          (go)
);

// File: tb/sim_sig_analyzer.sv
`timescale 1ns/1ps
module sim_sig_analyzer;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         din = 1'b0;
    logic         din_vld = 1'b0;
    logic         done = 1'b0;
    logic [W-1:0] golden = '0;
    logic [W-1:0] sig;
    logic         verdict_vld;
    logic         go;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sig_analyzer u0 (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .din         (din),
        .din_vld     (din_vld),
        .done        (done),
        .golden      (golden),
        .sig         (sig),
        .verdict_vld (verdict_vld),
        .go          (go)
    );

    // Long division of an 8-bit polynomial by X^5 + X^3 + X + 1.
    function automatic logic [W-1:0] ref_rem(input logic [7:0] v);
        logic [7:0] r;
        r = v;
        for (int k = 7; k >= 5; k--) begin
            if (r[k]) r = r ^ (8'b0010_1011 << (k - 5));
        end
        return r[W-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) begin
            din = v[k]; din_vld = 1'b1; step();
        end
        din_vld = 1'b0; din = 1'b0;
    endtask

    task automatic ask(input logic [W-1:0] g, input bit exp_go, input string tag);
        golden = g; done = 1'b1; step(); done = 1'b0;
        check(verdict_vld === 1'b1, tag, int'(verdict_vld), 1);
        check(go === exp_go, tag, int'(go), int'(exp_go));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        step(); step();
        // R1: reset state
        check(sig === 5'd0, "R1 sig", int'(sig), 0);
        check(go === 1'b0, "R1 go", int'(go), 0);
        check(verdict_vld === 1'b0, "R1 vld", int'(verdict_vld), 0);
        rst = 1'b0; step();

        // R6: fixed stream X7..X0 = 1,0,0,0,1,0,1,0
        do_clear();
        shift_byte(8'b1000_1010);
        check(sig === 5'b01101, "R6 signature", int'(sig), 13);
        ask(5'b01101, 1'b1, "R6 go");

        // R4 R5 R7: exhaustive sweep of 8-bit streams
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] e;
            e = ref_rem(8'(v));
            do_clear();
            check(sig === 5'd0, "R2 seed", int'(sig), 0);
            shift_byte(8'(v));
            check(sig === e, "R4 remainder", int'(sig), int'(e));
            ask(e, 1'b1, "R7 match");
            ask(e ^ 5'(1 << (v % W)), 1'b0, "R7 mismatch");
        end

        // R8: go holds with no done; R7 no verdict pulse
        do_clear();
        shift_byte(8'h5A);
        ask(ref_rem(8'h5A), 1'b1, "R8 setup");
        golden = 5'h1F;
        step();
        check(verdict_vld === 1'b0, "R7 single pulse", int'(verdict_vld), 0);
        check(go === 1'b1, "R8 hold", int'(go), 1);
        step();
        check(go === 1'b1, "R8 hold2", int'(go), 1);

        // R3: idle with toggling din
        held = sig;
        for (int k = 0; k < 4; k++) begin
            din = k[0]; din_vld = 1'b0; step();
            check(sig === held, "R3 hold", int'(sig), int'(held));
        end

        // R2: clear beats a shift
        check(sig !== 5'd0, "R2 precondition", int'(sig), 1);
        clr = 1'b1; din = 1'b1; din_vld = 1'b1; step();
        clr = 1'b0; din_vld = 1'b0; din = 1'b0;
        check(sig === 5'd0, "R2 priority", int'(sig), 0);

        // R9: bit with done is shifted but excluded from verdict
        shift_byte(8'hC3);
        held = sig;
        golden = held; done = 1'b1; din = 1'b1; din_vld = 1'b1; step();
        done = 1'b0; din_vld = 1'b0; din = 1'b0;
        check(go === 1'b1, "R9 verdict", int'(go), 1);
        begin
            logic [W-1:0] e9;
            e9 = {held[W-2:0], 1'b1} ^ (held[W-1] ? 5'b01011 : 5'b00000);
            check(sig === e9, "R9 shifted", int'(sig), int'(e9));
        end

        // R1: reset again mid-state
        rst = 1'b1; step();
        check(sig === 5'd0, "R1 re-reset sig", int'(sig), 0);
        check(go === 1'b0, "R1 re-reset go", int'(go), 0);
        rst = 1'b0; step();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule